// File: doc/BRIEF.md
# Training Firmware Loader with Readback Verify

This block moves a training firmware image out of a 32-bit, byte-addressed source memory and into a register space that is 16 bits wide. It drives the register space as a bus master. The image has two parts, an instruction region and a data region. Each 32-bit source word is split into two half-words. The low half goes to target address N and the high half goes to N+1. Once both regions are written, the block reads every target pair back and rebuilds the 32-bit word as low plus high shifted left by 16. It compares that word with a fresh read of the source and counts every word that differs. One counter covers both regions.

A start pulse launches a load, and an image-type select chooses where the image sits in the source. The block remembers the type of the last load it finished. A new request for that same type copies and checks nothing and reports completion at once. The first request after reset always runs in full.

Top module: `fw_image_loader`

## Requirements
- R1: After reset, `done_o` is low, `tgt_valid_o` and `src_rd_o` are low, and `err_cnt_o` is zero.
- R2: Target addresses are fixed by the region and the word index w. The instruction region starts at 0x50000 and the data region at 0x54000. Word w of a region writes its low half-word (bits 15:0) to base+2w and its high half-word (bits 31:16) to base+2w+1, in that order. `tgt_write_o` is 1 for writes and 0 for reads.
- R3: Source addresses are byte addresses aligned to 4. Word w of the instruction region is read from SRC_BASE+off+4w. Word w of the data region is read from SRC_BASE+off+IMEM_BYTES+4w. The offset off is 0 when `img_sel_i`=0 and ALT_OFFSET when `img_sel_i`=1.
- R4: A full load runs in this order: all instruction writes, then all data writes, then all instruction readbacks, then all data readbacks. Each region is walked in rising word order.
- R5: During readback, a word counts as one error when {high,low} differs from the source word. A word with both halves wrong also counts once. The count runs across both regions.
- R6: A start with the same type as the last finished load starts no source or target transfer. `done_o` goes high in the cycle after the start, and `err_cnt_o` reads zero.
- R7: The first start after reset always performs a full load, whatever `img_sel_i` is.
- R8: Once `tgt_valid_o` is high, it stays high with address, direction and write data unchanged until `tgt_ready_i`. Read data is taken only in the cycle where `tgt_ready_i` is high.
- R9: `done_o` is a single-cycle pulse. `err_cnt_o` is cleared by an accepted start and otherwise holds until the next accepted start.
- R10: A start pulse while a load is in progress is ignored. The running sequence is unchanged and only one `done_o` pulse appears.
- R11: Each source read returns its data one cycle after `src_rd_o`. The block issues one source read for each word it copies and one for each word it verifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle load request |
| img_sel_i | input | 1 | Image type chosen with the request |
| src_rd_o | output | 1 | Source read strobe |
| src_addr_o | output | SRC_AW | Source byte address |
| src_rdata_i | input | 32 | Source data, valid the cycle after the strobe |
| tgt_valid_o | output | 1 | Target transfer request |
| tgt_write_o | output | 1 | 1 = write, 0 = read |
| tgt_addr_o | output | TGT_AW | Target half-word address |
| tgt_wdata_o | output | 16 | Target write data |
| tgt_ready_i | input | 1 | Target accepts the transfer this cycle |
| tgt_rdata_i | input | 16 | Target read data, valid with ready |
| done_o | output | 1 | Completion pulse |
| err_cnt_o | output | CNT_W | Mismatched word count of the last load |

## Verification
A skipped request is due exactly one cycle after the start is sampled, so the bench drives the start on a falling edge and checks `done_o` at the next falling edge. A full load takes a number of cycles that depends on how the target ready stalls. For that case the bench waits on `done_o` one falling edge at a time. Then it checks that the pulse has dropped one cycle later and that the error count stays unchanged for several more cycles. Every target and source transfer is logged on the falling edge before the edge that completes it. The log is then compared in order against an address, direction and data sequence that the bench computes from the region bases, the word counts and the image offset.

// File: rtl/fw_image_loader.sv
module fw_image_loader #(
  parameter int SRC_AW = 32,
  parameter int TGT_AW = 20,
  parameter logic [TGT_AW-1:0] IMEM_BASE = 'h50000,
  parameter logic [TGT_AW-1:0] DMEM_BASE = 'h54000,
  parameter int IMEM_BYTES = 32768,
  parameter int DMEM_BYTES = 16384,
  parameter int ALT_OFFSET = 49152,
  parameter logic [SRC_AW-1:0] SRC_BASE = '0,
  localparam int IMEM_WORDS = IMEM_BYTES / 4,
  localparam int DMEM_WORDS = DMEM_BYTES / 4,
  localparam int MAX_WORDS = (IMEM_WORDS > DMEM_WORDS) ? IMEM_WORDS : DMEM_WORDS,
  localparam int WIDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int CNT_W = $clog2(IMEM_WORDS + DMEM_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              img_sel_i,
  output logic              src_rd_o,
  output logic [SRC_AW-1:0] src_addr_o,
  input  logic [31:0]       src_rdata_i,
  output logic              tgt_valid_o,
  output logic              tgt_write_o,
  output logic [TGT_AW-1:0] tgt_addr_o,
  output logic [15:0]       tgt_wdata_o,
  input  logic              tgt_ready_i,
  input  logic [15:0]       tgt_rdata_i,
  output logic              done_o,
  output logic [CNT_W-1:0]  err_cnt_o
);

  typedef enum logic [2:0] {S_IDLE, S_SRD, S_SWAIT, S_LO, S_HI, S_DONE} state_t;

  state_t            state;
  logic              img_sel, last_sel, last_vld;
  logic              in_data, verify;
  logic [WIDX_W-1:0] widx;
  logic [31:0]       word;
  logic [15:0]       lo_q;
  logic              last_word, same_type;

  assign last_word = in_data ? (widx == WIDX_W'(DMEM_WORDS - 1))
                             : (widx == WIDX_W'(IMEM_WORDS - 1));
  assign same_type = last_vld && (last_sel == img_sel_i);

  assign src_rd_o   = (state == S_SRD);
  assign src_addr_o = SRC_BASE
                    + (img_sel ? SRC_AW'(ALT_OFFSET) : '0)
                    + (in_data ? SRC_AW'(IMEM_BYTES) : '0)
                    + (SRC_AW'(widx) << 2);

  assign tgt_valid_o = (state == S_LO) || (state == S_HI);
  assign tgt_write_o = tgt_valid_o && !verify;
  assign tgt_addr_o  = (in_data ? DMEM_BASE : IMEM_BASE)
                     + (TGT_AW'(widx) << 1)
                     + TGT_AW'(state == S_HI);
  assign tgt_wdata_o = (state == S_HI) ? word[31:16] : word[15:0];
  assign done_o      = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      img_sel   <= 1'b0;
      last_sel  <= 1'b0;
      last_vld  <= 1'b0;
      in_data   <= 1'b0;
      verify    <= 1'b0;
      widx      <= '0;
      word      <= '0;
      lo_q      <= '0;
      err_cnt_o <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          err_cnt_o <= '0;
          img_sel   <= img_sel_i;
          in_data   <= 1'b0;
          verify    <= 1'b0;
          widx      <= '0;
          state     <= same_type ? S_DONE : S_SRD;
        end
        S_SRD:   state <= S_SWAIT;
        S_SWAIT: begin
          word  <= src_rdata_i;
          state <= S_LO;
        end
        S_LO: if (tgt_ready_i) begin
          lo_q  <= tgt_rdata_i;
          state <= S_HI;
        end
        S_HI: if (tgt_ready_i) begin
          if (verify && ({tgt_rdata_i, lo_q} != word))
            err_cnt_o <= err_cnt_o + 1'b1;
          state <= S_SRD;
          if (!last_word) begin
            widx <= widx + 1'b1;
          end else begin
            widx <= '0;
            if (!in_data) begin
              in_data <= 1'b1;
            end else if (!verify) begin
              in_data <= 1'b0;
              verify  <= 1'b1;
            end else begin
              state <= S_DONE;
            end
          end
        end
        S_DONE: begin
          last_vld <= 1'b1;
          last_sel <= img_sel;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fw_image_loader_chk.sv
module fw_image_loader_chk #(
  parameter int SRC_AW = 32,
  parameter int TGT_AW = 20,
  parameter int CNT_W = 8,
  parameter logic [TGT_AW-1:0] IMEM_BASE = 'h50000,
  parameter logic [TGT_AW-1:0] DMEM_BASE = 'h54000,
  parameter int IMEM_BYTES = 32768,
  parameter int DMEM_BYTES = 16384
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_o,
  input logic              src_rd_o,
  input logic [SRC_AW-1:0] src_addr_o,
  input logic              tgt_valid_o,
  input logic              tgt_write_o,
  input logic [TGT_AW-1:0] tgt_addr_o,
  input logic [15:0]       tgt_wdata_o,
  input logic              tgt_ready_i,
  input logic [CNT_W-1:0]  err_cnt_o
);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_quiet_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!tgt_valid_o && !src_rd_o));

  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid_o && !tgt_ready_i) |=> (tgt_valid_o && $stable(tgt_addr_o)
      && $stable(tgt_write_o) && $stable(tgt_wdata_o)));

  p_src_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_o |-> (src_addr_o[1:0] == 2'b00));

  p_addr_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid_o |-> (((tgt_addr_o - IMEM_BASE) < TGT_AW'(IMEM_BYTES / 2))
                  || ((tgt_addr_o - DMEM_BASE) < TGT_AW'(DMEM_BYTES / 2))));

  p_err_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_o != $past(err_cnt_o)) |->
      ((err_cnt_o == $past(err_cnt_o) + 1'b1) || (err_cnt_o == '0)));

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_rd_o && tgt_valid_o));

endmodule

bind fw_image_loader fw_image_loader_chk #(
  .SRC_AW(SRC_AW), .TGT_AW(TGT_AW), .CNT_W(CNT_W),
  .IMEM_BASE(IMEM_BASE), .DMEM_BASE(DMEM_BASE),
  .IMEM_BYTES(IMEM_BYTES), .DMEM_BYTES(DMEM_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done_o(done_o),
  .src_rd_o(src_rd_o), .src_addr_o(src_addr_o),
  .tgt_valid_o(tgt_valid_o), .tgt_write_o(tgt_write_o),
  .tgt_addr_o(tgt_addr_o), .tgt_wdata_o(tgt_wdata_o),
  .tgt_ready_i(tgt_ready_i), .err_cnt_o(err_cnt_o)
);

// File: tb/fw_image_loader_tb.sv
`timescale 1ns/1ps
module fw_image_loader_tb;
  localparam int SRC_AW = 32;
  localparam int TGT_AW = 20;
  localparam int IMB = 16;
  localparam int DMB = 8;
  localparam int ALT = 64;
  localparam int IW = IMB / 4;
  localparam int DW = DMB / 4;
  localparam int CW = $clog2(IW + DW + 1);
  localparam int NT = (IW + DW) * 4;
  localparam int NS = (IW + DW) * 2;

  logic clk = 0, rst_n = 0, start = 0, sel = 0;
  logic src_rd, tgt_valid, tgt_write, tgt_ready = 0, done;
  logic [SRC_AW-1:0] src_addr;
  logic [31:0] src_rdata = '0;
  logic [TGT_AW-1:0] tgt_addr;
  logic [15:0] tgt_wdata, tgt_rdata;
  logic [CW-1:0] err_cnt;

  always #5 clk = ~clk;

  fw_image_loader #(.SRC_AW(SRC_AW), .TGT_AW(TGT_AW), .IMEM_BYTES(IMB),
    .DMEM_BYTES(DMB), .ALT_OFFSET(ALT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .img_sel_i(sel),
    .src_rd_o(src_rd), .src_addr_o(src_addr), .src_rdata_i(src_rdata),
    .tgt_valid_o(tgt_valid), .tgt_write_o(tgt_write), .tgt_addr_o(tgt_addr),
    .tgt_wdata_o(tgt_wdata), .tgt_ready_i(tgt_ready), .tgt_rdata_i(tgt_rdata),
    .done_o(done), .err_cnt_o(err_cnt));

  int checks = 0, errors = 0, ndone = 0, cyc = 0;
  logic [15:0] tmem [0:15];
  logic        cmask [0:15];
  logic [TGT_AW-1:0] la [0:63];
  logic              lw [0:63];
  logic [15:0]       ld [0:63];
  logic [SRC_AW-1:0] sa [0:63];
  int nt = 0, ns = 0;
  logic [7:0] lfsr = 8'h5B;

  function automatic logic [31:0] srcword(input logic [SRC_AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C5A_0000;
  endfunction

  function automatic int tidx(input logic [TGT_AW-1:0] a);
    return (a >= 20'h54000) ? 8 + int'(a - 20'h54000) : int'(a - 20'h50000);
  endfunction

  assign tgt_rdata = tgt_ready ? tmem[tidx(tgt_addr)] : 16'hDEAD;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tgt_ready = lfsr[0] | lfsr[3];
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    if (done) ndone++;
    if (src_rd) begin
      src_rdata = srcword(src_addr);
      if (ns < 64) sa[ns] = src_addr;
      ns++;
    end
    if (tgt_valid && tgt_ready) begin
      if (nt < 64) begin la[nt] = tgt_addr; lw[nt] = tgt_write; ld[nt] = tgt_wdata; end
      nt++;
      if (tgt_write) tmem[tidx(tgt_addr)] = tgt_wdata ^ (cmask[tidx(tgt_addr)] ? 16'h0100 : 16'h0);
    end
  end

  task automatic pulse_start(input logic s);
    start = 1; sel = s;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(done, req, 0, 1);
  endtask

  task automatic check_seq(input logic s, input string req);
    int k = 0, m = 0;
    int off = s ? ALT : 0;
    chk(nt == NT, {req, " target count"}, nt, NT);
    chk(ns == NS, {req, " source count R11"}, ns, NS);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 2; r++)
        for (int w = 0; w < (r ? DW : IW); w++) begin
          logic [31:0] sw = srcword(SRC_AW'(off + r * IMB + 4 * w));
          chk(sa[m] == SRC_AW'(off + r * IMB + 4 * w), "R3 source address", sa[m], off + r * IMB + 4 * w);
          m++;
          for (int h = 0; h < 2; h++) begin
            logic [TGT_AW-1:0] ea = (r ? 20'h54000 : 20'h50000) + TGT_AW'(2 * w + h);
            chk(la[k] == ea, "R2 R4 target address", la[k], ea);
            chk(lw[k] == (p == 0), "R4 direction", lw[k], p == 0);
            if (p == 0) chk(ld[k] == (h ? sw[31:16] : sw[15:0]), "R2 half-word data", ld[k], h ? sw[31:16] : sw[15:0]);
            k++;
          end
        end
  endtask

  task automatic full_load(input logic s, input int exp_err, input bit poke);
    int d0;
    nt = 0; ns = 0; d0 = ndone;
    pulse_start(s);
    if (poke) begin
      repeat (10) @(negedge clk);
      pulse_start(!s);
    end
    wait_done("R7 full load completes");
    @(negedge clk);
    chk(!done, "R9 done single cycle", done, 0);
    chk(ndone - d0 == 1, "R10 one done per load", ndone - d0, 1);
    check_seq(s, "R4");
    chk(err_cnt == CW'(exp_err), "R5 R8 error count", err_cnt, exp_err);
    repeat (5) @(negedge clk);
    chk(err_cnt == CW'(exp_err), "R9 error count held", err_cnt, exp_err);
  endtask

  initial begin
    int e;
    for (int i = 0; i < 16; i++) begin tmem[i] = '0; cmask[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!done && !tgt_valid && !src_rd && err_cnt == 0, "R1 reset state",
        {done, tgt_valid, src_rd}, 0);
    rst_n = 1;
    @(negedge clk);

    full_load(1'b0, 0, 0);

    nt = 0; ns = 0;
    pulse_start(1'b0);
    chk(done, "R6 skip done next cycle", done, 1);
    chk(err_cnt == 0, "R6 skip error count", err_cnt, 0);
    repeat (4) @(negedge clk);
    chk(nt == 0 && ns == 0, "R6 skip no traffic", nt + ns, 0);

    cmask[3] = 1; cmask[4] = 1; cmask[5] = 1; cmask[8] = 1;
    e = 0;
    for (int w = 0; w < IW; w++) if (cmask[2*w] || cmask[2*w+1]) e++;
    for (int w = 0; w < DW; w++) if (cmask[8+2*w] || cmask[9+2*w]) e++;
    full_load(1'b1, e, 1);

    for (int i = 0; i < 16; i++) cmask[i] = 0;
    full_load(1'b0, 0, 0);

    nt = 0; ns = 0;
    pulse_start(1'b0);
    chk(done && err_cnt == 0, "R6 second skip", done, 1);
    repeat (3) @(negedge clk);
    chk(nt == 0 && ns == 0, "R6 second skip no traffic", nt + ns, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule